// File: doc/BRIEF.md
# Management Slot Interpreter for a Serial Audio Codec Link

This block sits behind a link deserializer that has already cut each 256-bit frame into slots. It receives one slot word per strobe together with the slot number, plus a pulse that marks each new frame. It decodes the tag slot (slot 0) into a codec-ready flag, a 12-bit slot-valid mask and a 2-bit codec ID. It pairs the command/status address slot (slot 1) with the command/status data slot (slot 2) of the same frame into one register-access event, and it passes the upper 16 bits of each valid audio slot on as a sample.

The slot-valid mask from the tag gates every later slot of the frame. A slot whose valid bit is clear produces no output. The same RTL serves either link direction. The parameter `DIR_INBOUND` selects the slot-1 layout and its reserved-bit rule: 0 for controller-to-codec, 1 for codec-to-controller. Slot words arrive right-justified in a 20-bit bus; the 16-bit tag occupies bits 15:0.

Top module: `ac97m_slot_decoder`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `tag_stb`, `acc_stb` and `smp_stb` are low.
- R2: One cycle after a slot-0 strobe, `tag_stb` is high with `tag_ready` = bit 15, `tag_valid` = bits 14:3 and `tag_codec` = bits 1:0 of that word; bits 19:16 are ignored.
- R3: `tag_rsv_err` reports bit 2 of the slot-0 word (the reserved tag bit) being set.
- R4: A slot s in 1..12 is accepted only if bit (12 - s) of the mask from the latest slot 0 of the current frame is set; a rejected slot produces no strobe on any output.
- R5: A `frm_start` pulse clears the mask and any pending slot-1 capture. A slot-0 strobe in the same cycle loads its mask anyway. Any other slot in that cycle is rejected.
- R6: `acc_stb` pulses one cycle after an accepted slot-2 strobe, only if an accepted slot 1 came earlier in the same frame. `acc_addr` = slot-1 bits 18:12 and `acc_data` = slot-2 bits 19:4.
- R7: With `DIR_INBOUND` = 0: `acc_rd` = slot-1 bit 19 (1 = read), `acc_req` = 0, and any set bit in slot-1 bits 11:0 raises `acc_rsv_err`.
- R8: With `DIR_INBOUND` = 1: `acc_rd` = 0, `acc_req` = slot-1 bits 11:2, and a set slot-1 bit 19 or any set bit in bits 1:0 raises `acc_rsv_err`.
- R9: In either direction, any set bit in slot-2 bits 3:0 also raises `acc_rsv_err`.
- R10: `acc_odd_err` is high on an event whose register address has bit 0 set.
- R11: One cycle after an accepted strobe of slot 3..11, `smp_stb` is high with `smp_chan` = slot number and `smp_data` = word bits 19:4. Slot 12 and slot numbers 13..15 never produce a sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_start | input | 1 | Pulse marking the start of a new frame |
| slot_stb | input | 1 | Slot word present this cycle |
| slot_idx | input | 4 | Slot number of the present word |
| slot_data | input | 20 | Slot word, MSB first, right-justified |
| tag_stb | output | 1 | Tag decoded |
| tag_ready | output | 1 | Codec-ready flag |
| tag_valid | output | 12 | Slot-valid mask |
| tag_codec | output | 2 | Codec ID |
| tag_rsv_err | output | 1 | Reserved tag bit set |
| acc_stb | output | 1 | Register-access event |
| acc_rd | output | 1 | Read flag (outbound only) |
| acc_addr | output | 7 | Register address |
| acc_data | output | 16 | Register data |
| acc_req | output | 10 | Data-request bits (inbound only) |
| acc_rsv_err | output | 1 | Reserved bits set in slot 1 or 2 |
| acc_odd_err | output | 1 | Odd register address |
| smp_stb | output | 1 | Audio sample present |
| smp_chan | output | 4 | Slot number of the sample |
| smp_data | output | 16 | Upper 16 bits of the audio slot |

## Verification
The bench builds two instances with default widths, one with `DIR_INBOUND` = 0 and one with `DIR_INBOUND` = 1, and feeds both the same slot stream. Every slot-1 and slot-2 word is therefore judged under both reserved-bit rules and both read/request interpretations at once. Random frames with random masks and reserved bits reach the gating of each slot position. Directed frames cover a frame start that coincides with slot 0 or slot 2, a slot arriving before any tag, slot numbers above 12, and odd addresses.

// File: rtl/ac97m_pkg.sv
package ac97m_pkg;
  parameter int IDX_W = 4;
  typedef logic [IDX_W-1:0] slot_idx_t;

  localparam slot_idx_t SLOT_TAG    = 4'd0;
  localparam slot_idx_t SLOT_ADDR   = 4'd1;
  localparam slot_idx_t SLOT_DATA   = 4'd2;
  localparam slot_idx_t AUDIO_FIRST = 4'd3;
  localparam slot_idx_t AUDIO_LAST  = 4'd11;
  localparam int        NUM_CODES   = 1 << IDX_W;
endpackage

// File: rtl/ac97m_tag_unit.sv
module ac97m_tag_unit
  import ac97m_pkg::*;
#(
  parameter int TAG_W   = 16,
  parameter int VALID_W = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frm_start,
  input  logic                 slot_stb,
  input  slot_idx_t            slot_idx,
  input  logic [TAG_W-1:0]     tag_word,
  output logic [NUM_CODES-1:0] slot_en,
  output logic                 tag_stb,
  output logic                 tag_ready,
  output logic [VALID_W-1:0]   tag_valid,
  output logic [TAG_W-VALID_W-3:0] tag_codec,
  output logic                 tag_rsv_err
);
  localparam int READY_POS = TAG_W - 1;
  localparam int VALID_LSB = READY_POS - VALID_W;
  localparam int RSV_POS   = VALID_LSB - 1;
  localparam int CODEC_W   = RSV_POS;

  logic [VALID_W-1:0] mask_q;
  logic               is_tag;

  assign is_tag = slot_stb && (slot_idx == SLOT_TAG);

  // slot s is flagged by mask bit (VALID_W - s); a frame start blanks all
  genvar s;
  generate
    for (s = 0; s < NUM_CODES; s++) begin : g_en
      if (s == 0) begin : g_tag
        assign slot_en[s] = 1'b1;
      end else if (s <= VALID_W) begin : g_flag
        assign slot_en[s] = !frm_start && mask_q[VALID_W-s];
      end else begin : g_none
        assign slot_en[s] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q      <= '0;
      tag_stb     <= 1'b0;
      tag_ready   <= 1'b0;
      tag_valid   <= '0;
      tag_codec   <= '0;
      tag_rsv_err <= 1'b0;
    end else begin
      tag_stb <= is_tag;
      if (is_tag) begin
        mask_q      <= tag_word[READY_POS-1:VALID_LSB];
        tag_ready   <= tag_word[READY_POS];
        tag_valid   <= tag_word[READY_POS-1:VALID_LSB];
        tag_codec   <= tag_word[CODEC_W-1:0];
        tag_rsv_err <= tag_word[RSV_POS];
      end else if (frm_start) begin
        mask_q <= '0;
      end
    end
  end
endmodule

// File: rtl/ac97m_reg_unit.sv
module ac97m_reg_unit
  import ac97m_pkg::*;
#(
  parameter int SLOT_W      = 20,
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 16,
  parameter int REQ_W       = 10,
  parameter bit DIR_INBOUND = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_start,
  input  logic              slot_stb,
  input  slot_idx_t         slot_idx,
  input  logic [SLOT_W-1:0] slot_data,
  input  logic              en_addr,
  input  logic              en_data,
  output logic              acc_stb,
  output logic              acc_rd,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] acc_data,
  output logic [REQ_W-1:0]  acc_req,
  output logic              acc_rsv_err,
  output logic              acc_odd_err
);
  localparam int TOP_POS  = SLOT_W - 1;
  localparam int ADDR_LSB = TOP_POS - ADDR_W;
  localparam int REQ_LSB  = ADDR_LSB - REQ_W;
  localparam int DRSV_W   = SLOT_W - DATA_W;

  // per-direction interpretation of the address slot
  logic             s1_rd;
  logic [REQ_W-1:0] s1_req;
  logic             s1_rsv;

  generate
    if (DIR_INBOUND) begin : g_inbound
      assign s1_rd  = 1'b0;
      assign s1_req = slot_data[ADDR_LSB-1:REQ_LSB];
      assign s1_rsv = slot_data[TOP_POS] || (slot_data[REQ_LSB-1:0] != '0);
    end else begin : g_outbound
      assign s1_rd  = slot_data[TOP_POS];
      assign s1_req = '0;
      assign s1_rsv = (slot_data[ADDR_LSB-1:0] != '0);
    end
  endgenerate

  logic              seen_q;
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [REQ_W-1:0]  req_q;
  logic              rsv_q;
  logic              take_addr;
  logic              fire;
  logic              d_rsv;

  assign take_addr = slot_stb && (slot_idx == SLOT_ADDR) && en_addr;
  assign fire      = slot_stb && (slot_idx == SLOT_DATA) && en_data && seen_q;
  assign d_rsv     = (slot_data[DRSV_W-1:0] != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q      <= 1'b0;
      rd_q        <= 1'b0;
      addr_q      <= '0;
      req_q       <= '0;
      rsv_q       <= 1'b0;
      acc_stb     <= 1'b0;
      acc_rd      <= 1'b0;
      acc_addr    <= '0;
      acc_data    <= '0;
      acc_req     <= '0;
      acc_rsv_err <= 1'b0;
      acc_odd_err <= 1'b0;
    end else begin
      acc_stb <= fire;
      if (frm_start) seen_q <= 1'b0;
      if (take_addr) begin
        seen_q <= 1'b1;
        rd_q   <= s1_rd;
        addr_q <= slot_data[TOP_POS-1:ADDR_LSB];
        req_q  <= s1_req;
        rsv_q  <= s1_rsv;
      end
      if (fire) begin
        seen_q      <= 1'b0;
        acc_rd      <= rd_q;
        acc_addr    <= addr_q;
        acc_data    <= slot_data[TOP_POS:DRSV_W];
        acc_req     <= req_q;
        acc_rsv_err <= rsv_q || d_rsv;
        acc_odd_err <= addr_q[0];
      end
    end
  end
endmodule

// File: rtl/ac97m_audio_unit.sv
module ac97m_audio_unit
  import ac97m_pkg::*;
#(
  parameter int SMP_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 slot_stb,
  input  slot_idx_t            slot_idx,
  input  logic [SMP_W-1:0]     slot_upper,
  input  logic [NUM_CODES-1:0] slot_en,
  output logic                 smp_stb,
  output slot_idx_t            smp_chan,
  output logic [SMP_W-1:0]     smp_data
);
  logic take;

  assign take = slot_stb && (slot_idx >= AUDIO_FIRST) &&
                (slot_idx <= AUDIO_LAST) && slot_en[slot_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_stb  <= 1'b0;
      smp_chan <= '0;
      smp_data <= '0;
    end else begin
      smp_stb <= take;
      if (take) begin
        smp_chan <= slot_idx;
        smp_data <= slot_upper;
      end
    end
  end
endmodule

// File: rtl/ac97m_slot_decoder.sv
module ac97m_slot_decoder
  import ac97m_pkg::*;
#(
  parameter bit DIR_INBOUND = 1'b0,
  parameter int SLOT_W      = 20,
  parameter int TAG_W       = 16,
  parameter int VALID_W     = 12,
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 16,
  parameter int REQ_W       = 10,
  parameter int SMP_W       = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         frm_start,
  input  logic                         slot_stb,
  input  logic [3:0]                   slot_idx,
  input  logic [SLOT_W-1:0]            slot_data,
  output logic                         tag_stb,
  output logic                         tag_ready,
  output logic [VALID_W-1:0]           tag_valid,
  output logic [TAG_W-VALID_W-3:0]     tag_codec,
  output logic                         tag_rsv_err,
  output logic                         acc_stb,
  output logic                         acc_rd,
  output logic [ADDR_W-1:0]            acc_addr,
  output logic [DATA_W-1:0]            acc_data,
  output logic [REQ_W-1:0]             acc_req,
  output logic                         acc_rsv_err,
  output logic                         acc_odd_err,
  output logic                         smp_stb,
  output logic [3:0]                   smp_chan,
  output logic [SMP_W-1:0]             smp_data
);
  logic [NUM_CODES-1:0] slot_en;

  ac97m_tag_unit #(
    .TAG_W   (TAG_W),
    .VALID_W (VALID_W)
  ) u_tag (
    .clk         (clk),
    .rst         (rst),
    .frm_start   (frm_start),
    .slot_stb    (slot_stb),
    .slot_idx    (slot_idx),
    .tag_word    (slot_data[TAG_W-1:0]),
    .slot_en     (slot_en),
    .tag_stb     (tag_stb),
    .tag_ready   (tag_ready),
    .tag_valid   (tag_valid),
    .tag_codec   (tag_codec),
    .tag_rsv_err (tag_rsv_err)
  );

  ac97m_reg_unit #(
    .SLOT_W      (SLOT_W),
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .REQ_W       (REQ_W),
    .DIR_INBOUND (DIR_INBOUND)
  ) u_reg (
    .clk         (clk),
    .rst         (rst),
    .frm_start   (frm_start),
    .slot_stb    (slot_stb),
    .slot_idx    (slot_idx),
    .slot_data   (slot_data),
    .en_addr     (slot_en[SLOT_ADDR]),
    .en_data     (slot_en[SLOT_DATA]),
    .acc_stb     (acc_stb),
    .acc_rd      (acc_rd),
    .acc_addr    (acc_addr),
    .acc_data    (acc_data),
    .acc_req     (acc_req),
    .acc_rsv_err (acc_rsv_err),
    .acc_odd_err (acc_odd_err)
  );

  ac97m_audio_unit #(
    .SMP_W (SMP_W)
  ) u_audio (
    .clk        (clk),
    .rst        (rst),
    .slot_stb   (slot_stb),
    .slot_idx   (slot_idx),
    .slot_upper (slot_data[SLOT_W-1:SLOT_W-SMP_W]),
    .slot_en    (slot_en),
    .smp_stb    (smp_stb),
    .smp_chan   (smp_chan),
    .smp_data   (smp_data)
  );
endmodule

// File: rtl/ac97m_slot_decoder_chk.sv
module ac97m_slot_decoder_chk (
  input logic        clk,
  input logic        rst,
  input logic        frm_start,
  input logic        slot_stb,
  input logic [3:0]  slot_idx,
  input logic [2:0]  slot_low,
  input logic        tag_stb,
  input logic        tag_rsv_err,
  input logic        acc_stb,
  input logic        acc_addr0,
  input logic        acc_odd_err,
  input logic        smp_stb,
  input logic [3:0]  smp_chan
);
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!tag_stb && !acc_stb && !smp_stb));

  assert_tag_follows_slot0_R2: assert property (@(posedge clk) disable iff (rst)
    tag_stb |-> $past(slot_stb && slot_idx == 4'd0));

  assert_tag_reserved_R3: assert property (@(posedge clk) disable iff (rst)
    tag_stb |-> (tag_rsv_err == $past(slot_low[2])));

  assert_one_event_kind_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tag_stb, acc_stb, smp_stb}));

  assert_frame_start_gates_R5: assert property (@(posedge clk) disable iff (rst)
    frm_start |=> (!acc_stb && !smp_stb));

  assert_access_follows_slot2_R6: assert property (@(posedge clk) disable iff (rst)
    acc_stb |-> $past(slot_stb && slot_idx == 4'd2 && !frm_start));

  assert_odd_flag_R10: assert property (@(posedge clk) disable iff (rst)
    acc_stb |-> (acc_odd_err == acc_addr0));

  assert_sample_range_R11: assert property (@(posedge clk) disable iff (rst)
    smp_stb |-> (smp_chan >= 4'd3 && smp_chan <= 4'd11));
endmodule

bind ac97m_slot_decoder ac97m_slot_decoder_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .frm_start   (frm_start),
  .slot_stb    (slot_stb),
  .slot_idx    (slot_idx),
  .slot_low    (slot_data[2:0]),
  .tag_stb     (tag_stb),
  .tag_rsv_err (tag_rsv_err),
  .acc_stb     (acc_stb),
  .acc_addr0   (acc_addr[0]),
  .acc_odd_err (acc_odd_err),
  .smp_stb     (smp_stb),
  .smp_chan    (smp_chan)
);

// File: tb/ac97m_slot_decoder_bench.sv
module ac97m_slot_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frm_start = 1'b0;
  logic        slot_stb = 1'b0;
  logic [3:0]  slot_idx = '0;
  logic [19:0] slot_data = '0;

  always #10 clk = ~clk;

  logic [1:0]  tag_stb, tag_ready, tag_rsv_err, acc_stb, acc_rd, acc_rsv_err, acc_odd_err, smp_stb;
  logic [11:0] tag_valid [2];
  logic [1:0]  tag_codec [2];
  logic [6:0]  acc_addr  [2];
  logic [15:0] acc_data  [2];
  logic [9:0]  acc_req   [2];
  logic [3:0]  smp_chan  [2];
  logic [15:0] smp_data  [2];

  ac97m_slot_decoder #(.DIR_INBOUND(1'b0)) u_ac97m_slot_decoder (
    .clk(clk), .rst(rst), .frm_start(frm_start), .slot_stb(slot_stb),
    .slot_idx(slot_idx), .slot_data(slot_data),
    .tag_stb(tag_stb[0]), .tag_ready(tag_ready[0]), .tag_valid(tag_valid[0]),
    .tag_codec(tag_codec[0]), .tag_rsv_err(tag_rsv_err[0]),
    .acc_stb(acc_stb[0]), .acc_rd(acc_rd[0]), .acc_addr(acc_addr[0]),
    .acc_data(acc_data[0]), .acc_req(acc_req[0]), .acc_rsv_err(acc_rsv_err[0]),
    .acc_odd_err(acc_odd_err[0]), .smp_stb(smp_stb[0]), .smp_chan(smp_chan[0]),
    .smp_data(smp_data[0]));

  ac97m_slot_decoder #(.DIR_INBOUND(1'b1)) u_ac97m_slot_decoder_inb (
    .clk(clk), .rst(rst), .frm_start(frm_start), .slot_stb(slot_stb),
    .slot_idx(slot_idx), .slot_data(slot_data),
    .tag_stb(tag_stb[1]), .tag_ready(tag_ready[1]), .tag_valid(tag_valid[1]),
    .tag_codec(tag_codec[1]), .tag_rsv_err(tag_rsv_err[1]),
    .acc_stb(acc_stb[1]), .acc_rd(acc_rd[1]), .acc_addr(acc_addr[1]),
    .acc_data(acc_data[1]), .acc_req(acc_req[1]), .acc_rsv_err(acc_rsv_err[1]),
    .acc_odd_err(acc_odd_err[1]), .smp_stb(smp_stb[1]), .smp_chan(smp_chan[1]),
    .smp_data(smp_data[1]));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [11:0] m_mask = '0;
  logic        m_seen = 1'b0;
  logic [19:0] m_s1 = '0;

  function automatic bit slot_ok(logic [11:0] mask, int s);
    if (s == 0) return 1'b1;
    if (s > 12) return 1'b0;
    return mask[12-s];
  endfunction

  // {stb, ready, valid[12], codec[2], rsv}
  function automatic logic [16:0] exp_tag(bit stb, logic [3:0] idx, logic [19:0] d);
    if (stb && idx == 4'd0) return {1'b1, d[15], d[14:3], d[1:0], d[2]};
    return '0;
  endfunction

  // {stb, chan[4], data[16]}
  function automatic logic [20:0] exp_smp(bit stb, logic [3:0] idx, logic [19:0] d, logic [11:0] mask);
    if (stb && idx >= 4'd3 && idx <= 4'd11 && slot_ok(mask, int'(idx))) return {1'b1, idx, d[19:4]};
    return '0;
  endfunction

  // {stb, rd, addr[7], data[16], req[10], rsv, odd}
  function automatic logic [36:0] exp_acc(bit dir, logic [19:0] s1, logic [19:0] d);
    logic rd, r1;
    logic [9:0] req;
    if (dir) begin
      rd = 1'b0; req = s1[11:2]; r1 = s1[19] || (s1[1:0] != 2'b0);   // R8
    end else begin
      rd = s1[19]; req = '0; r1 = (s1[11:0] != 12'b0);                 // R7
    end
    return {1'b1, rd, s1[18:12], d[19:4], req, r1 || (d[3:0] != 4'b0), s1[12]}; // R9 R10
  endfunction

  task automatic check(string req, int width, logic [63:0] act, logic [63:0] exp);
    bit ok;
    checks++;
    if (exp[width-1] == 1'b0) ok = (act[width-1] == 1'b0);
    else ok = (act == exp);
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(bit fs, bit stb, logic [3:0] idx, logic [19:0] d);
    logic [11:0] eff;
    logic [16:0] et;
    logic [20:0] es;
    logic [36:0] ea [2];
    bit          fire;
    frm_start = fs; slot_stb = stb; slot_idx = idx; slot_data = d;
    eff = fs ? 12'b0 : m_mask;
    et = exp_tag(stb, idx, d);
    es = exp_smp(stb, idx, d, eff);
    fire = stb && idx == 4'd2 && slot_ok(eff, 2) && m_seen;
    for (int k = 0; k < 2; k++) ea[k] = fire ? exp_acc(k[0], m_s1, d) : '0;
    if (fs) m_seen = 1'b0;
    if (stb && idx == 4'd0) m_mask = d[14:3];
    else if (fs) m_mask = '0;
    if (stb && idx == 4'd1 && slot_ok(eff, 1)) begin m_s1 = d; m_seen = 1'b1; end
    if (fire) m_seen = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      check("R2 R3 tag", 17, 64'({tag_stb[k], tag_ready[k], tag_valid[k], tag_codec[k], tag_rsv_err[k]}), 64'(et));
      check(k == 0 ? "R6 R7 R9 R10 R4 R5 access outbound" : "R6 R8 R9 R10 R4 R5 access inbound", 37,
            64'({acc_stb[k], acc_rd[k], acc_addr[k], acc_data[k], acc_req[k], acc_rsv_err[k], acc_odd_err[k]}), 64'(ea[k]));
      check("R11 R4 sample", 21, 64'({smp_stb[k], smp_chan[k], smp_data[k]}), 64'(es));
    end
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 4'd0, 20'h0);
  endtask

  function automatic logic [19:0] tag_word(bit rdy, logic [11:0] v, bit rsv, logic [1:0] cid);
    return {4'h0, rdy, v, rsv, cid};
  endfunction

  task automatic random_frame();
    logic [19:0] d;
    step(1'b1, 1'b0, 4'd0, 20'h0);
    step(1'b0, 1'b1, 4'd0, {4'($urandom), 1'($urandom), 12'($urandom), ($urandom % 8 == 0), 2'($urandom)});
    for (int s = 1; s <= 12; s++) begin
      d = 20'($urandom);
      if ($urandom % 2 == 0) d[11:0] = (s == 1) ? {10'($urandom), 2'b00} : {8'($urandom), 4'h0};
      if ($urandom % 2 == 0) d[12] = 1'b0;
      step(1'b0, 1'b1, 4'(s), d);
      if ($urandom % 4 == 0) idle();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk); @(negedge clk);
    // R1: strobes quiet while reset is held
    for (int k = 0; k < 2; k++)
      check("R1 reset", 3, 64'({tag_stb[k], acc_stb[k], smp_stb[k]}), 64'(3'b000));
    rst = 1'b0;
    idle();

    // R4: slot before any tag in a frame is rejected
    step(1'b1, 1'b0, 4'd0, 20'h0);
    step(1'b0, 1'b1, 4'd3, 20'hABCDE);
    // R2 R3: tag with all valid bits, reserved bit set, upper nibble junk
    step(1'b0, 1'b1, 4'd0, 20'hF0000 | tag_word(1'b1, 12'hFFF, 1'b1, 2'd2));
    // R7 R8 R10: odd address, read bit, request bits, nonzero reserved in slot 2
    step(1'b0, 1'b1, 4'd1, {1'b1, 7'h13, 10'h2A5, 2'b01});
    step(1'b0, 1'b1, 4'd2, 20'h12345);
    // R11: slot 11 taken, slot 12 and codes 13..15 ignored
    step(1'b0, 1'b1, 4'd11, 20'h55AA0);
    step(1'b0, 1'b1, 4'd12, 20'h77770);
    step(1'b0, 1'b1, 4'd13, 20'h11110);
    step(1'b0, 1'b1, 4'd15, 20'h22220);
    // R6: slot 2 without slot 1 in this frame gives no event
    step(1'b0, 1'b1, 4'd2, 20'h0BEE0);

    // R5: frame start coincident with slot 0 still loads the mask
    step(1'b1, 1'b1, 4'd0, tag_word(1'b0, 12'hC00, 1'b0, 2'd1));
    step(1'b0, 1'b1, 4'd1, {1'b0, 7'h22, 12'h000});
    // R5: frame start coincident with slot 2 drops the pending capture
    step(1'b1, 1'b1, 4'd2, 20'hFACE0);
    step(1'b0, 1'b1, 4'd0, tag_word(1'b1, 12'h600, 1'b0, 2'd0));
    step(1'b0, 1'b1, 4'd2, 20'h13570);
    // R4: mask without slot 1 flagged
    step(1'b1, 1'b0, 4'd0, 20'h0);
    step(1'b0, 1'b1, 4'd0, tag_word(1'b1, 12'h400, 1'b0, 2'd3));
    step(1'b0, 1'b1, 4'd1, {1'b0, 7'h10, 12'h000});
    step(1'b0, 1'b1, 4'd2, 20'h24680);
    step(1'b0, 1'b1, 4'd3, 20'h99990);
    idle();

    for (int f = 0; f < 80; f++) random_frame();
    idle();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule